// File: doc/BRIEF.md
# Machine Status Register Unit

This block keeps the live fields of the machine-mode status CSR for a small 32-bit core whose floating-point unit is optional. It holds the global interrupt enable, the saved copy of that enable, the privilege level in force before the last trap, and the floating-point context state. The pipeline drives it with single-cycle pulses: a trap being taken, a trap return (`mret`) retiring, and a floating-point instruction retiring, with a flag for single-precision stores. Software reads and writes the register through a plain CSR port made of a write enable, a 12-bit address and 32-bit data.

Three parameters say whether user mode, an FPU, and the option of keeping floating-point operands in the integer registers are present. These parameters tie the previous-privilege and FP-state fields to constants where the hardware has nothing to track. The full register word is always visible on `status_word`, so the core can take the return privilege and interrupt enable from it. `csr_rdata` carries the same word only when the address selects this CSR.

Top module: `mstat_unit`

## Requirements
- R1: After a synchronous reset, the interrupt enable (bit 3), the saved enable (bit 7) and the FP state (bits 14:13) are 0, and the previous privilege (bits 12:11) is 11. The word reads 0x0000_1800.
- R2: Only bits 31, 14:13, 12:11, 7 and 3 can ever read as 1. `csr_rdata` is zero when `csr_addr` is not 0x300.
- R3: On a trap pulse, the saved enable takes the old interrupt enable, and the interrupt enable clears. With user mode present, the previous privilege captures `cur_priv` (00 captures 00, and any other value captures 11).
- R4: On an `mret` pulse without a trap, the interrupt enable takes the saved enable, and the saved enable becomes 1. The previous privilege becomes the lowest supported level: 00 with user mode, 11 without.
- R5: A trap has priority over a same-cycle `mret`. A software write that coincides with a trap or an `mret` is dropped entirely.
- R6: A software write to address 0x300 loads bit 3, bit 7, bits 14:13 and bits 12:11. With user mode present, the value 10 for bits 12:11 leaves the previous privilege unchanged, while 00 and 11 are taken.
- R7: A retiring FP instruction that is not a single-precision store sets the FP state to 11 (Dirty). This takes priority over a same-cycle software write of that field. A retiring single-precision store leaves the FP state unchanged.
- R8: The FP state reads 00 and ignores both writes and retirements when no FPU is configured, or when the FPU keeps its operands in integer registers. Bit 31 reads 1 exactly when the FP state is 11.
- R9: Without user mode, the previous privilege always reads 11, whatever is written and whatever the trap or return sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Software CSR write enable |
| csr_addr | input | 12 | CSR address for the read and the write |
| csr_wdata | input | 32 | Software write data |
| cur_priv | input | 2 | Privilege level in force when a trap is taken |
| trap_take | input | 1 | Pulse: trap taken this cycle |
| mret_exec | input | 1 | Pulse: trap return executed this cycle |
| fp_retire | input | 1 | Pulse: a floating-point instruction retired |
| fp_is_store | input | 1 | The retiring FP instruction is a single-precision store |
| csr_rdata | output | 32 | Read data for the addressed CSR |
| status_word | output | 32 | Current register word |

## Verification
The hardest case to reach from the ports is a two-deep trap nest that is unwound by two returns. It is the only way to show that the saved enable is a one-entry history: the inner return restores 0, and the outer return restores the value it stored. The stimulus table builds this nest from a known enabled state, fires a trap, an `mret` and a write in the same cycle, and fires an FP retirement on top of a pending write. The configuration masks come from sibling instances that share the same stimulus, each built with different parameters.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] MSTAT_ADDR = 12'h300;

    localparam int MIE_BIT  = 3;
    localparam int MPIE_BIT = 7;
    localparam int MPP_LO   = 11;
    localparam int FS_LO    = 13;
    localparam int SD_BIT   = DATA_W - 1;

    localparam logic [1:0] PRIV_USER    = 2'b00;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam logic [1:0] PRIV_RSVD    = 2'b10;

    typedef enum logic [1:0] {
        FS_OFF   = 2'b00,
        FS_INIT  = 2'b01,
        FS_CLEAN = 2'b10,
        FS_DIRTY = 2'b11
    } fs_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        fs_e        fs;
    } mstat_fields_t;

    function automatic logic [DATA_W-1:0] pack_word(mstat_fields_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MIE_BIT]           = f.mie;
        w[MPIE_BIT]          = f.mpie;
        w[MPP_LO+1:MPP_LO]   = f.mpp;
        w[FS_LO+1:FS_LO]     = f.fs;
        w[SD_BIT]            = (f.fs == FS_DIRTY);
        return w;
    endfunction

    function automatic logic mpp_acceptable(logic [1:0] v);
        return v != PRIV_RSVD;
    endfunction

    function automatic logic [1:0] legal_priv(logic [1:0] v);
        return (v == PRIV_USER) ? PRIV_USER : PRIV_MACHINE;
    endfunction

    function automatic bit fp_state_live(bit has_fpu, bit fp_in_int);
        return has_fpu && !fp_in_int;
    endfunction
endpackage

// File: rtl/mstat_ie.sv
module mstat_ie (
    input  logic clk,
    input  logic rst,
    input  logic trap_take,
    input  logic mret_exec,
    input  logic wr_en,
    input  logic wr_mie,
    input  logic wr_mpie,
    output logic mie,
    output logic mpie
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mie  <= 1'b0;
            mpie <= 1'b0;
        end else if (trap_take) begin
            mpie <= mie;
            mie  <= 1'b0;
        end else if (mret_exec) begin
            mie  <= mpie;
            mpie <= 1'b1;
        end else if (wr_en) begin
            mie  <= wr_mie;
            mpie <= wr_mpie;
        end
    end

    assert_trap_clears_mie_R3: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> !mie);
    assert_trap_saves_mie_R3: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> mpie == $past(mie));
    assert_mret_restores_R4: assert property (@(posedge clk) disable iff (rst)
        (mret_exec && !trap_take) |=> (mie == $past(mpie)) && mpie);
endmodule

// File: rtl/mstat_mpp.sv
module mstat_mpp #(
    parameter bit HAS_USER = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trap_take,
    input  logic       mret_exec,
    input  logic [1:0] cur_priv,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output logic [1:0] mpp
);
    import mstat_pkg::*;

    generate
        if (HAS_USER) begin : g_track
            always_ff @(posedge clk) begin
                if (rst) begin
                    mpp <= PRIV_MACHINE;
                end else if (trap_take) begin
                    mpp <= legal_priv(cur_priv);
                end else if (mret_exec) begin
                    mpp <= PRIV_USER;
                end else if (wr_en && mpp_acceptable(wr_val)) begin
                    mpp <= wr_val;
                end
            end

            assert_mpp_never_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
                mpp != PRIV_RSVD);
            assert_rsvd_write_holds_R6: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_val == PRIV_RSVD && !trap_take && !mret_exec) |=> $stable(mpp));
            assert_mret_lowest_R4: assert property (@(posedge clk) disable iff (rst)
                (mret_exec && !trap_take) |=> mpp == PRIV_USER);
        end else begin : g_fixed
            assign mpp = PRIV_MACHINE;
        end
    endgenerate
endmodule

// File: rtl/mstat_fs.sv
module mstat_fs #(
    parameter bit HAS_FPU   = 1'b1,
    parameter bit FP_IN_INT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fp_retire,
    input  logic       fp_is_store,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    output mstat_pkg::fs_e fs
);
    import mstat_pkg::*;

    localparam bit LIVE = fp_state_live(HAS_FPU, FP_IN_INT);

    generate
        if (LIVE) begin : g_live
            logic make_dirty;
            assign make_dirty = fp_retire && !fp_is_store;

            always_ff @(posedge clk) begin
                if (rst) begin
                    fs <= FS_OFF;
                end else if (make_dirty) begin
                    fs <= FS_DIRTY;
                end else if (wr_en) begin
                    fs <= fs_e'(wr_val);
                end
            end

            assert_fp_op_dirties_R7: assert property (@(posedge clk) disable iff (rst)
                (fp_retire && !fp_is_store) |=> fs == FS_DIRTY);
            assert_fp_store_keeps_R7: assert property (@(posedge clk) disable iff (rst)
                (fp_retire && fp_is_store && !wr_en) |=> $stable(fs));
        end else begin : g_off
            assign fs = FS_OFF;
        end
    endgenerate
endmodule

// File: rtl/mstat_unit.sv
module mstat_unit #(
    parameter bit HAS_USER  = 1'b1,
    parameter bit HAS_FPU   = 1'b1,
    parameter bit FP_IN_INT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    input  logic [1:0]  cur_priv,
    input  logic        trap_take,
    input  logic        mret_exec,
    input  logic        fp_retire,
    input  logic        fp_is_store,
    output logic [31:0] csr_rdata,
    output logic [31:0] status_word
);
    import mstat_pkg::*;

    logic          hit;
    logic          sw_wr;
    mstat_fields_t fields;

    assign hit   = (csr_addr == MSTAT_ADDR);
    assign sw_wr = csr_we && hit && !trap_take && !mret_exec;

    mstat_ie u_ie (
        .clk       (clk),
        .rst       (rst),
        .trap_take (trap_take),
        .mret_exec (mret_exec),
        .wr_en     (sw_wr),
        .wr_mie    (csr_wdata[MIE_BIT]),
        .wr_mpie   (csr_wdata[MPIE_BIT]),
        .mie       (fields.mie),
        .mpie      (fields.mpie)
    );

    mstat_mpp #(.HAS_USER(HAS_USER)) u_mpp (
        .clk       (clk),
        .rst       (rst),
        .trap_take (trap_take),
        .mret_exec (mret_exec),
        .cur_priv  (cur_priv),
        .wr_en     (sw_wr),
        .wr_val    (csr_wdata[MPP_LO+1:MPP_LO]),
        .mpp       (fields.mpp)
    );

    mstat_fs #(.HAS_FPU(HAS_FPU), .FP_IN_INT(FP_IN_INT)) u_fs (
        .clk         (clk),
        .rst         (rst),
        .fp_retire   (fp_retire),
        .fp_is_store (fp_is_store),
        .wr_en       (sw_wr),
        .wr_val      (csr_wdata[FS_LO+1:FS_LO]),
        .fs          (fields.fs)
    );

    assign status_word = pack_word(fields);
    assign csr_rdata   = hit ? status_word : '0;

    assert_trap_drops_write_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_take && csr_we && hit && csr_wdata[MIE_BIT]) |=> !status_word[MIE_BIT]);
    assert_mret_drops_write_R5: assert property (@(posedge clk) disable iff (rst)
        (mret_exec && !trap_take && csr_we && hit && !csr_wdata[MPIE_BIT]) |=> status_word[MPIE_BIT]);
endmodule

// File: tb/tb_mstat_unit.sv
module tb_mstat_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic [1:0]  cur_priv;
    logic        trap_take, mret_exec, fp_retire, fp_is_store;
    logic [31:0] rd_main, st_main, rd_nu, st_nu, rd_zx, st_zx, rd_nf, st_nf;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mstat_unit #(.HAS_USER(1), .HAS_FPU(1), .FP_IN_INT(0)) dut (
        .clk, .rst, .csr_we, .csr_addr, .csr_wdata, .cur_priv, .trap_take,
        .mret_exec, .fp_retire, .fp_is_store, .csr_rdata(rd_main), .status_word(st_main));
    mstat_unit #(.HAS_USER(0), .HAS_FPU(1), .FP_IN_INT(0)) dut_nu (
        .clk, .rst, .csr_we, .csr_addr, .csr_wdata, .cur_priv, .trap_take,
        .mret_exec, .fp_retire, .fp_is_store, .csr_rdata(rd_nu), .status_word(st_nu));
    mstat_unit #(.HAS_USER(1), .HAS_FPU(1), .FP_IN_INT(1)) dut_zx (
        .clk, .rst, .csr_we, .csr_addr, .csr_wdata, .cur_priv, .trap_take,
        .mret_exec, .fp_retire, .fp_is_store, .csr_rdata(rd_zx), .status_word(st_zx));
    mstat_unit #(.HAS_USER(0), .HAS_FPU(0), .FP_IN_INT(0)) dut_nf (
        .clk, .rst, .csr_we, .csr_addr, .csr_wdata, .cur_priv, .trap_take,
        .mret_exec, .fp_retire, .fp_is_store, .csr_rdata(rd_nf), .status_word(st_nf));

    typedef struct packed {
        logic        trap;
        logic        mret;
        logic        we;
        logic [31:0] wd;
        logic        fr;
        logic        fst;
        logic [1:0]  priv;
        logic [31:0] exp;
    } vec_t;

    // Expectations for the main instance (user mode, FPU, separate FP registers).
    localparam vec_t VECS [16] = '{
        '{1'b0,1'b0,1'b1,32'hFFFF_FFFF,1'b0,1'b0,2'b00,32'h8000_7888}, // R2 R6 R8 write all ones
        '{1'b0,1'b0,1'b1,32'h0000_0008,1'b0,1'b0,2'b00,32'h0000_0008}, // R6
        '{1'b0,1'b0,1'b1,32'h0000_1008,1'b0,1'b0,2'b00,32'h0000_0008}, // R6 reserved 10 holds
        '{1'b1,1'b0,1'b0,32'h0,        1'b0,1'b0,2'b00,32'h0000_0080}, // R3 trap from user
        '{1'b1,1'b0,1'b0,32'h0,        1'b0,1'b0,2'b11,32'h0000_1800}, // R3 nested trap
        '{1'b0,1'b1,1'b0,32'h0,        1'b0,1'b0,2'b00,32'h0000_0080}, // R4 inner return
        '{1'b0,1'b1,1'b0,32'h0,        1'b0,1'b0,2'b00,32'h0000_0088}, // R4 outer return
        '{1'b1,1'b1,1'b1,32'h0,        1'b0,1'b0,2'b11,32'h0000_1880}, // R5 trap wins
        '{1'b0,1'b1,1'b1,32'hFFFF_FFFF,1'b0,1'b0,2'b00,32'h0000_0088}, // R5 write dropped on mret
        '{1'b0,1'b0,1'b1,32'h0000_2000,1'b0,1'b0,2'b00,32'h0000_2000}, // R6 FS initial
        '{1'b0,1'b0,1'b0,32'h0,        1'b1,1'b1,2'b00,32'h0000_2000}, // R7 store keeps FS
        '{1'b0,1'b0,1'b0,32'h0,        1'b1,1'b0,2'b00,32'h8000_6000}, // R7 R8 dirty, SD
        '{1'b0,1'b0,1'b1,32'h0000_4000,1'b1,1'b0,2'b00,32'h8000_6000}, // R7 retire beats write
        '{1'b0,1'b0,1'b1,32'h0000_4000,1'b0,1'b0,2'b00,32'h0000_4000}, // R6 FS clean
        '{1'b0,1'b0,1'b0,32'h0,        1'b1,1'b1,2'b00,32'h0000_4000}, // R7 store keeps clean
        '{1'b1,1'b0,1'b0,32'h0,        1'b1,1'b0,2'b00,32'h8000_6000}  // R3 R7 trap with FP op
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_we = 0; csr_addr = 12'h300; csr_wdata = '0; cur_priv = 2'b00;
        trap_take = 0; mret_exec = 0; fp_retire = 0; fp_is_store = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic sw_write(input logic [31:0] d);
        idle(); csr_we = 1; csr_wdata = d;
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        do_reset();
        // R1 reset state on every configuration
        check("R1 main", st_main, 32'h0000_1800);
        check("R1 no-user", st_nu, 32'h0000_1800);
        check("R1 fp-in-int", st_zx, 32'h0000_1800);
        check("R1 no-fpu", st_nf, 32'h0000_1800);

        // Configuration masks (R2 R8 R9)
        sw_write(32'hFFFF_FFFF);
        check("R2 mask main", rd_main, 32'h8000_7888);
        check("R2 R8 mask no-user", rd_nu, 32'h8000_7888);
        check("R8 mask fp-in-int", rd_zx, 32'h0000_1888);
        check("R8 mask no-fpu", rd_nf, 32'h0000_1888);
        csr_addr = 12'h301; #1;
        check("R2 other address", rd_main, 32'h0);
        sw_write(32'h0);
        check("R9 no-user write 0", st_nu, 32'h0000_1800);
        check("R6 fp-in-int write 0", st_zx, 32'h0);
        check("R9 no-fpu write 0", st_nf, 32'h0000_1800);
        fp_retire = 1; @(negedge clk); idle();
        check("R7 no-user dirty", st_nu, 32'h8000_7800);
        check("R8 fp-in-int ignores retire", st_zx, 32'h0);
        check("R8 no-fpu ignores retire", st_nf, 32'h0000_1800);
        mret_exec = 1; @(negedge clk); idle();
        check("R9 no-user mret", st_nu, 32'h8000_7880);
        check("R4 fp-in-int mret", st_zx, 32'h0000_0080);
        check("R9 no-fpu mret", st_nf, 32'h0000_1880);

        // Table walk on the main instance
        do_reset();
        foreach (VECS[i]) begin
            trap_take = VECS[i].trap; mret_exec = VECS[i].mret; csr_we = VECS[i].we;
            csr_wdata = VECS[i].wd; fp_retire = VECS[i].fr; fp_is_store = VECS[i].fst;
            cur_priv = VECS[i].priv; csr_addr = 12'h300;
            @(negedge clk);
            idle(); #1;
            check($sformatf("R3-table vec %0d", i), st_main, VECS[i].exp);
            check($sformatf("R2 readback vec %0d", i), rd_main, VECS[i].exp);
        end

        // R6 write to another address has no effect
        csr_addr = 12'h305; csr_we = 1; csr_wdata = 32'h0000_0088;
        @(negedge clk); idle(); #1;
        check("R6 foreign address ignored", rd_main, 32'h8000_6000);

        // R1 reset mid-run
        do_reset();
        check("R1 reset after activity", st_main, 32'h0000_1800);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule